// File: doc/BRIEF.md
# Page-Wrapping I2C Slave Front End

This block is the serial front end of a small addressable store. A system clock oversamples the open-drain SCL and SDA lines. The block recognises START, repeated START and STOP conditions and compares the first byte against a 7-bit device address. The following byte sets an internal 8-bit pointer. Data bytes after that are written through a register-file port at the pointer. Each write advances the pointer, and the pointer stays inside the current 16-byte page: only the low four bits count, and they roll over from offset 15 back to offset 0.

A random-address read takes four steps. The master writes the device address and the pointer byte, issues a repeated START, and sends the device address again with the read bit set. The slave then sends bytes from the pointer, MSB first, for as long as the master acknowledges each one. It uses the same in-page pointer advance as for writes. A NACK from the master ends the read, and the slave releases SDA until the next START.

The controller has seven states:
- IDLE waits for a START.
- RX_BITS shifts in eight bits on SCL rising edges, then moves to RX_DECIDE.
- RX_DECIDE acts on the next SCL falling edge. A matching device byte or any later byte goes to ACK. A mismatched device byte goes to IGNORE.
- ACK holds SDA low for the ninth clock, then goes to TX_BITS in a read or back to RX_BITS in a write.
- TX_BITS drives eight bits, changing them on SCL falling edges, then moves to TX_ACK.
- TX_ACK samples the master's answer. It returns to TX_BITS on ACK and goes to IGNORE on NACK.
- IGNORE leaves SDA released.

A START from any state goes to RX_BITS. A STOP from any state goes to IDLE.

Top module: `i2c_page_slave`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START in any state, including in the middle of a transfer, restarts byte reception with a device-address byte. A STOP releases SDA and returns the block to idle.
- R2: A first byte whose upper seven bits equal DEV_ADDR is acknowledged by pulling SDA low during the ninth SCL clock. Bit 0 of that byte selects the direction: 0 means write and 1 means read.
- R3: After a device byte that does not match, the slave never acknowledges and writes nothing until the next START.
- R4: In a write, the byte after the device byte is acknowledged and loaded into the pointer.
- R5: Each later write byte is acknowledged and produces one single-cycle mem_we pulse, with mem_addr equal to the pointer and mem_wdata equal to the byte.
- R6: After each byte the pointer's low four bits advance modulo 16 and its upper bits are unchanged. For example, twelve bytes written from offset 11 land at offsets 11 to 15 and then 0 to 6, and leave the pointer at offset 7 of the same page.
- R7: After a repeated START and a device byte with bit 0 = 1, the slave acknowledges and sends mem_rdata from the pointer, MSB first. Bits change only after SCL falls.
- R8: While the master acknowledges in the ninth clock, the slave sends the next byte. The pointer advances after every byte sent, with the same in-page wrap as R6.
- R9: After a master NACK, the slave drives SDA no further until a START.
- R10: sda_oe changes only while SCL is low.
- R11: After reset, sda_oe and mem_we are 0 and mem_addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| mem_we | output | 1 | One-cycle write strobe to the register file |
| mem_addr | output | 8 | Current pointer, used for both reads and writes |
| mem_wdata | output | 8 | Byte received for a write |
| mem_rdata | input | 8 | Register-file contents at mem_addr (combinational) |

## Verification
The assertions assume that the bus obeys the protocol. SDA never rises or falls while SCL is high except as a deliberate START or STOP, and a START or STOP never occurs while the slave holds SDA low. Each SCL phase also lasts several system clocks, so the synchroniser sees every edge. The bench master keeps to this by changing SDA only a quarter period after SCL has fallen, holding each SCL level for five or more clocks, and releasing SDA before each START or STOP. The stimulus also writes the memory through the bus before any byte is read back, so read data is never undefined.

// File: rtl/i2c_pw_pkg.sv
package i2c_pw_pkg;

    // Controller states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX_BITS,
        ST_RX_DECIDE,
        ST_ACK,
        ST_TX_BITS,
        ST_TX_ACK,
        ST_IGNORE
    } slv_state_e;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        K_DEV,
        K_REG,
        K_DATA
    } byte_kind_e;

    localparam int BYTE_W = 8;

endpackage

// File: rtl/i2c_pw_line_sync.sv
module i2c_pw_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev;

    assign raw = {sda_in, scl_in};

    // One synchroniser chain per bus line; idle bus level is high
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pipe    <= '1;
                prev[g] <= 1'b1;
            end else begin
                pipe    <= {pipe[STAGES-2:0], raw[g]};
                prev[g] <= pipe[STAGES-1];
            end
        end
        assign synced[g] = pipe[STAGES-1];
    end

    assign scl_lvl   = synced[0];
    assign sda_lvl   = synced[1];
    assign scl_rise  = synced[0] & ~prev[0];
    assign scl_fall  = ~synced[0] & prev[0];
    assign start_det = synced[0] & prev[0] & prev[1] & ~synced[1];
    assign stop_det  = synced[0] & prev[0] & ~prev[1] & synced[1];

endmodule

// File: rtl/i2c_pw_page_ptr.sv
module i2c_pw_page_ptr #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);

    logic [ADDR_W-1:0] ptr_next;

    // Advance only the in-page offset; a page as wide as the space wraps it all
    if (PAGE_W >= ADDR_W) begin : g_flat
        assign ptr_next = ptr + 1'b1;
    end else begin : g_paged
        logic [PAGE_W-1:0] offs_next;
        assign offs_next = ptr[PAGE_W-1:0] + 1'b1;
        assign ptr_next  = {ptr[ADDR_W-1:PAGE_W], offs_next};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (step) begin
            ptr <= ptr_next;
        end
    end

endmodule

// File: rtl/i2c_page_slave.sv
module i2c_page_slave
    import i2c_pw_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         PAGE_W      = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    output logic       mem_we,
    output logic [7:0] mem_addr,
    output logic [7:0] mem_wdata,
    input  logic [7:0] mem_rdata
);

    localparam int ADDR_W = BYTE_W;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    i2c_pw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_i),
        .sda_in   (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    slv_state_e        state_q, state_d;
    byte_kind_e        kind_q, kind_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [BYTE_W-1:0] rx_q, rx_d;
    logic [BYTE_W-1:0] tx_q, tx_d;
    logic              oe_q, oe_d;
    logic              rd_q, rd_d;
    logic              mack_q, mack_d;
    logic              ptr_load, ptr_step, wr_stb;
    logic [ADDR_W-1:0] ptr;

    i2c_pw_page_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (ptr_load),
        .load_val(rx_q),
        .step    (ptr_step),
        .ptr     (ptr)
    );

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= K_DEV;
            cnt_q   <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            oe_q    <= 1'b0;
            rd_q    <= 1'b0;
            mack_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            cnt_q   <= cnt_d;
            rx_q    <= rx_d;
            tx_q    <= tx_d;
            oe_q    <= oe_d;
            rd_q    <= rd_d;
            mack_q  <= mack_d;
        end
    end

    // Next-state and control process
    always_comb begin
        state_d  = state_q;
        kind_d   = kind_q;
        cnt_d    = cnt_q;
        rx_d     = rx_q;
        tx_d     = tx_q;
        oe_d     = oe_q;
        rd_d     = rd_q;
        mack_d   = mack_q;
        ptr_load = 1'b0;
        ptr_step = 1'b0;
        wr_stb   = 1'b0;

        if (stop_det) begin
            state_d = ST_IDLE;
            oe_d    = 1'b0;
        end else if (start_det) begin
            state_d = ST_RX_BITS;
            kind_d  = K_DEV;
            cnt_d   = '0;
            oe_d    = 1'b0;
            rd_d    = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: begin
                    oe_d = 1'b0;
                end
                ST_RX_BITS: begin
                    if (scl_rise) begin
                        rx_d  = {rx_q[BYTE_W-2:0], sda_lvl};
                        cnt_d = cnt_q + 1'b1;
                        if (cnt_q == LAST_BIT) begin
                            state_d = ST_RX_DECIDE;
                        end
                    end
                end
                ST_RX_DECIDE: begin
                    if (scl_fall) begin
                        unique case (kind_q)
                            K_DEV: begin
                                if (rx_q[BYTE_W-1:1] == DEV_ADDR) begin
                                    oe_d    = 1'b1;
                                    rd_d    = rx_q[0];
                                    kind_d  = K_REG;
                                    state_d = ST_ACK;
                                end else begin
                                    state_d = ST_IGNORE;
                                end
                            end
                            K_REG: begin
                                oe_d     = 1'b1;
                                ptr_load = 1'b1;
                                kind_d   = K_DATA;
                                state_d  = ST_ACK;
                            end
                            K_DATA: begin
                                oe_d     = 1'b1;
                                wr_stb   = 1'b1;
                                ptr_step = 1'b1;
                                state_d  = ST_ACK;
                            end
                            default: state_d = ST_IGNORE;
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        cnt_d = '0;
                        if (rd_q) begin
                            tx_d    = mem_rdata;
                            oe_d    = ~mem_rdata[BYTE_W-1];
                            state_d = ST_TX_BITS;
                        end else begin
                            oe_d    = 1'b0;
                            state_d = ST_RX_BITS;
                        end
                    end
                end
                ST_TX_BITS: begin
                    if (scl_fall) begin
                        if (cnt_q == LAST_BIT) begin
                            oe_d     = 1'b0;
                            ptr_step = 1'b1;
                            cnt_d    = '0;
                            state_d  = ST_TX_ACK;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                            tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
                            oe_d  = ~tx_q[BYTE_W-2];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        mack_d = sda_lvl;
                    end
                    if (scl_fall) begin
                        if (!mack_q) begin
                            tx_d    = mem_rdata;
                            oe_d    = ~mem_rdata[BYTE_W-1];
                            state_d = ST_TX_BITS;
                        end else begin
                            state_d = ST_IGNORE;
                        end
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    oe_d    = 1'b0;
                end
            endcase
        end
    end

    // Output process
    always_comb begin
        sda_oe    = oe_q;
        mem_we    = wr_stb;
        mem_addr  = ptr;
        mem_wdata = rx_q;
    end

endmodule

// File: rtl/i2c_page_slave_chk.sv
module i2c_page_slave_chk #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_lvl,
    input logic              start_det,
    input logic              stop_det,
    input logic              sda_oe,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);

    // R5
    wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R6
    page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W]))
                && (mem_addr[PAGE_W-1:0] == $past(mem_addr[PAGE_W-1:0]) + 1'b1));

    // R10
    sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_oe));

    // R1
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> !sda_oe);

    // R1
    cond_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_det, stop_det}));

endmodule

bind i2c_page_slave i2c_page_slave_chk #(.ADDR_W(8), .PAGE_W(PAGE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_lvl  (scl_lvl),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_oe   (sda_oe),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/i2c_page_slave_test.sv
module i2c_page_slave_test;

    localparam logic [6:0] DEV = 7'h50;
    localparam int Q = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_oe, mem_we;
    logic [7:0] mem_addr, mem_wdata, mem_rdata;

    logic [7:0] mem   [256];
    logic [7:0] lg_a  [256];
    logic [7:0] lg_d  [256];
    int         lg_n = 0;
    int         checks = 0;
    int         errors = 0;
    int         r10_bad = 0;
    logic       oe_prev = 1'b0;
    logic       scl_prev = 1'b1;

    assign sda_bus   = sda_m & ~sda_oe;
    assign mem_rdata = mem[mem_addr];

    i2c_page_slave #(.DEV_ADDR(DEV)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .mem_we   (mem_we),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // Register-file model and write log
    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            mem[mem_addr]      <= mem_wdata;
            lg_a[lg_n[7:0]]    <= mem_addr;
            lg_d[lg_n[7:0]]    <= mem_wdata;
            lg_n               <= lg_n + 1;
        end
    end

    // R10 monitor: SDA drive must not move while SCL stays high
    always @(posedge clk) begin
        if (rst_n && scl_m && scl_prev && (sda_oe !== oe_prev)) r10_bad = r10_bad + 1;
        oe_prev  <= sda_oe;
        scl_prev <= scl_m;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic m_start;
        sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic m_stop;
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b1; wt(Q);
    endtask

    task automatic m_bit(input logic b, output logic r);
        sda_m = b;    wt(Q);
        scl_m = 1'b1; wt(Q);
        r = sda_bus;  wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic m_wr_byte(input logic [7:0] b, output bit ack);
        logic r;
        for (int i = 7; i >= 0; i--) m_bit(b[i], r);
        m_bit(1'b1, r);
        ack = (r == 1'b0);
    endtask

    task automatic m_rd_byte(input logic nack, output logic [7:0] d);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            m_bit(1'b1, r);
            d[i] = r;
        end
        m_bit(nack, r);
    endtask

    function automatic logic [7:0] pg_addr(input logic [7:0] st, input int i);
        logic [3:0] off;
        off = st[3:0] + 4'(i);
        return {st[7:4], off};
    endfunction

    // Write n bytes from address a; data at each address is address ^ key
    task automatic wr_txn(input logic [7:0] a, input int n, input logic [7:0] key,
                          output int nacks);
        bit ack;
        nacks = 0;
        m_start;
        m_wr_byte({DEV, 1'b0}, ack); if (!ack) nacks++;
        m_wr_byte(a, ack);           if (!ack) nacks++;
        for (int i = 0; i < n; i++) begin
            m_wr_byte(pg_addr(a, i) ^ key, ack);
            if (!ack) nacks++;
        end
        m_stop;
    endtask

    // Random-address read of n bytes, verifying address ^ key
    task automatic rd_txn(input logic [7:0] a, input int n, input logic [7:0] key);
        bit ack;
        logic [7:0] d;
        logic r;
        m_start;
        m_wr_byte({DEV, 1'b0}, ack);
        check(ack, "R2 read header device ack", int'(ack), 1);
        m_wr_byte(a, ack);
        check(ack, "R4 read header address ack", int'(ack), 1);
        m_start;
        m_wr_byte({DEV, 1'b1}, ack);
        check(ack, "R7 read device ack after repeated START", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            m_rd_byte(i == n - 1, d);
            check(d == (pg_addr(a, i) ^ key), "R8 read data in-page sequence",
                  int'(d), int'(pg_addr(a, i) ^ key));
        end
        m_bit(1'b1, r);
        check(r == 1'b1, "R9 line released after master NACK", int'(r), 1);
        m_stop;
        check(mem_addr == pg_addr(a, n), "R8 pointer after read", int'(mem_addr),
              int'(pg_addr(a, n)));
    endtask

    bit done = 1'b0;

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int nk, base;
        bit ack;

        wt(4);
        rst_n = 1'b1;
        wt(4);
        // R11 reset state
        check(sda_oe == 1'b0, "R11 sda_oe after reset", int'(sda_oe), 0);
        check(mem_we == 1'b0, "R11 mem_we after reset", int'(mem_we), 0);
        check(mem_addr == 8'h00, "R11 mem_addr after reset", int'(mem_addr), 0);

        // R6: twelve bytes from offset 11 of page 0x20
        base = lg_n;
        wr_txn(8'h2B, 12, 8'hC3, nk);
        check(nk == 0, "R5 all write bytes acknowledged", nk, 0);
        check(lg_n - base == 12, "R5 one strobe per byte", lg_n - base, 12);
        for (int i = 0; i < 12; i++) begin
            check(lg_a[base + i] == pg_addr(8'h2B, i), "R6 write wrap address",
                  int'(lg_a[base + i]), int'(pg_addr(8'h2B, i)));
            check(lg_d[base + i] == (pg_addr(8'h2B, i) ^ 8'hC3), "R5 write data",
                  int'(lg_d[base + i]), int'(pg_addr(8'h2B, i) ^ 8'hC3));
        end
        check(mem_addr == 8'h27, "R6 pointer ends at offset 7", int'(mem_addr), 8'h27);
        check(sda_oe == 1'b0, "R1 released after STOP", int'(sda_oe), 0);

        // R6 sweep over every start offset in page 0x60
        for (int off = 0; off < 16; off++) begin
            logic [7:0] st;
            st = {4'h6, 4'(off)};
            base = lg_n;
            wr_txn(st, 5, 8'h96, nk);
            check(nk == 0, "R4 sweep acks", nk, 0);
            check(lg_n - base == 5, "R5 sweep strobe count", lg_n - base, 5);
            for (int i = 0; i < 5; i++) begin
                check(lg_a[base + i] == pg_addr(st, i), "R6 sweep address",
                      int'(lg_a[base + i]), int'(pg_addr(st, i)));
            end
            check(mem_addr == pg_addr(st, 5), "R6 sweep pointer end",
                  int'(mem_addr), int'(pg_addr(st, 5)));
        end

        // R3 mismatched device address
        base = lg_n;
        m_start;
        m_wr_byte({7'h51, 1'b0}, ack);
        check(!ack, "R3 no ack for other device", int'(ack), 0);
        m_wr_byte(8'h10, ack);
        check(!ack, "R3 no ack for following byte", int'(ack), 0);
        m_wr_byte(8'hEE, ack);
        check(!ack, "R3 no ack for data byte", int'(ack), 0);
        m_stop;
        check(lg_n == base, "R3 no write after mismatch", lg_n - base, 0);

        // R1 repeated START restarts the header
        base = lg_n;
        m_start;
        m_wr_byte({DEV, 1'b0}, ack);
        m_wr_byte(8'h70, ack);
        m_start;
        m_wr_byte({DEV, 1'b0}, ack);
        check(ack, "R1 device ack after restart", int'(ack), 1);
        m_wr_byte(8'h05, ack);
        m_wr_byte(8'h77, ack);
        m_stop;
        check(lg_n - base == 1, "R1 single write after restart", lg_n - base, 1);
        check(lg_a[base] == 8'h05, "R1 restart address", int'(lg_a[base]), 8'h05);
        check(lg_d[base] == 8'h77, "R1 restart data", int'(lg_d[base]), 8'h77);

        // R7/R8/R9 random-address reads with wrap
        wr_txn(8'h3D, 6, 8'h5A, nk);
        rd_txn(8'h3D, 5, 8'h5A);
        wr_txn(8'h9E, 3, 8'h33, nk);
        rd_txn(8'h9E, 3, 8'h33);
        rd_txn(8'h2B, 12, 8'hC3);

        // R10 over the whole run
        check(r10_bad == 0, "R10 sda_oe stable while SCL high", r10_bad, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule